// File: doc/BRIEF.md
# Asynchronous LCD Bus Write/Read Controller

This block is a bus master that converts single host requests into asynchronous parallel bus cycles toward an LCD controller with an integrated frame memory. A host presents a request that carries a direction (read or write), a register-select bit and, for writes, a 16-bit word. It holds `req_valid` until the block accepts the request. The block then runs one complete cycle on the LCD pins. That cycle has a chip select, a register-select line, two strobe pins and a 16-bit data bus, where the bus is split into an output half, an output enable and an input half.

Every access has three parts. First comes a setup phase of `SETUP+1` clocks with chip select low and no strobe. Then comes a data phase of `STROBE+1` clocks, in which the strobe is active for `STROBE` clocks and idle for one recovery clock. Last comes an optional hold phase of `HOLD` clocks. With `HOLD=0` the chip-select low time is therefore `(SETUP+1)+(STROBE+1)` clocks. Two timing sets exist. A split option sends reads to the read set. Without the split, reads and writes both use the write set.

A mode input picks the strobe encoding. In 8080 signalling the two strobe pins are active-low read and write strobes. In 6800 signalling the first pin carries an active-high enable pulse and the second carries a read/not-write level. For the 8080 case, a 72 MHz clock with SETUP=1, HOLD=0 and STROBE=5 meets a 100 ns write cycle with a 50 ns write-low pulse.

Top module: `lcd_pbus_master`

## Requirements
- R1: After reset, and whenever no access is in progress, the outputs are: `lcd_cs_n`=1, `req_ready`=1, `rsp_valid`=0 and `lcd_d_oe`=0. In 8080 mode both strobe pins are 1. In 6800 mode `lcd_oe_n` (enable) is 0 and `lcd_we_n` (R/W) is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the cycle in which `lcd_cs_n` is back at 1, and `lcd_cs_n` is never 0 while `req_ready` is 1.
- R3: `lcd_cs_n` stays low for (SETUP+1)+(STROBE+1)+HOLD consecutive clocks. A STROBE value of 0 is treated as 1.
- R4: The strobe is active for exactly STROBE consecutive clocks. Its first active clock comes after SETUP+1 clocks of chip select low.
- R5: In 8080 mode a write pulses `lcd_we_n` low while `lcd_oe_n` stays 1. `lcd_rs` equals `req_ram` (0 = register/command, 1 = display RAM) and stays constant for the whole chip-select low window.
- R6: In 8080 mode a read pulses `lcd_oe_n` low while `lcd_we_n` stays 1. `lcd_d_in` is sampled at the clock edge that ends the last strobe-active clock. That value appears on `rsp_rdata` with a single-clock `rsp_valid` pulse. Writes produce no `rsp_valid`.
- R7: In 6800 mode `lcd_oe_n` carries the enable, which is 1 for the STROBE clocks. `lcd_we_n` carries R/W, which is 1 for a read and 0 for a write and stays constant through the access.
- R8: During a write, `lcd_d_oe` is 1 and `lcd_d_out` holds the request word, stable, for every clock of chip select low. During a read, `lcd_d_oe` is 0.
- R9: With `cfg_split_timing`=1, reads use the read timing set and writes use the write set. With `cfg_split_timing`=0, both use the write set.
- R10: Timing, split and mode inputs are sampled only on the accept edge. Changing them during an access leaves that access unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode_6800 | input | 1 | 1 = 6800 signalling, 0 = 8080 |
| cfg_split_timing | input | 1 | 1 = reads use the read timing set |
| cfg_wr_setup | input | 8 | Write-set setup count |
| cfg_wr_strobe | input | 8 | Write-set strobe count |
| cfg_wr_hold | input | 8 | Write-set hold count |
| cfg_rd_setup | input | 8 | Read-set setup count |
| cfg_rd_strobe | input | 8 | Read-set strobe count |
| cfg_rd_hold | input | 8 | Read-set hold count |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle, able to accept |
| req_read | input | 1 | 1 = read, 0 = write |
| req_ram | input | 1 | Register-select value (1 = display RAM) |
| req_wdata | input | 16 | Write word |
| rsp_valid | output | 1 | One-clock pulse with read data |
| rsp_rdata | output | 16 | Captured read word |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rs | output | 1 | Register select |
| lcd_oe_n | output | 1 | 8080 read strobe / 6800 enable |
| lcd_we_n | output | 1 | 8080 write strobe / 6800 R/W |
| lcd_d_out | output | 16 | Data bus, driven value |
| lcd_d_oe | output | 1 | Data bus drive enable |
| lcd_d_in | input | 16 | Data bus, received value |

## Verification
The bench goes after the edges of the timing arithmetic. It uses zero setup, nonzero hold and a strobe count of zero. With these values, a counter that is off by one would stretch or shorten chip select or the strobe, and the clamp failing would give a strobe that never shows up or wraps to a very long pulse.

The bench model drives valid read data only while the read strobe is active. A design that captured one clock late would return the filler word instead.

Split versus shared timing sets are told apart by giving the two sets different lengths, so a wrong set selection shows up as the wrong pulse length. Timing and mode inputs are rewritten in the middle of an access, which catches a design that reads them live instead of latching them. In 6800 mode the bench checks the enable polarity and the R/W level, so a strobe map copied from 8080 fails.

// File: rtl/lcdb_pkg.sv
// Shared types for the LCD parallel bus master.
// Assumes all three timing counts share one width.
package lcdb_pkg;
    localparam int TW = 8;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_STRB  = 3'd2,
        PH_RECOV = 3'd3,
        PH_HOLD  = 3'd4
    } phase_t;

    typedef struct packed {
        logic [TW-1:0] setup;
        logic [TW-1:0] strobe;
        logic [TW-1:0] hold;
    } timing_t;
endpackage

// File: rtl/lcdb_tsel.sv
// Timing set selector: picks the read or the write set for a request and
// clamps a zero strobe count to one. Purely combinational; the caller
// latches the result on the accept edge.
module lcdb_tsel
    import lcdb_pkg::*;
(
    input  logic          split,
    input  logic          is_read,
    input  logic [TW-1:0] wr_setup,
    input  logic [TW-1:0] wr_strobe,
    input  logic [TW-1:0] wr_hold,
    input  logic [TW-1:0] rd_setup,
    input  logic [TW-1:0] rd_strobe,
    input  logic [TW-1:0] rd_hold,
    output timing_t       tim
);
    logic use_rd;

    // Choose the set and apply the minimum strobe length.
    always_comb begin
        use_rd     = split && is_read;
        tim.setup  = use_rd ? rd_setup : wr_setup;
        tim.hold   = use_rd ? rd_hold  : wr_hold;
        tim.strobe = use_rd ? rd_strobe : wr_strobe;
        if (tim.strobe == '0) begin
            tim.strobe = {{(TW-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/lcdb_seq.sv
// Access sequencer: walks setup, strobe, recovery and hold phases with one
// down-counter. Timing is latched on start, so config changes during an
// access are ignored. Assumes tim_in.strobe >= 1.
module lcdb_seq
    import lcdb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  timing_t tim_in,
    output phase_t  phase,
    output logic    last_strb
);
    timing_t       tim_q;
    logic [TW-1:0] cnt;

    // Phase and counter progression.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            tim_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        tim_q <= tim_in;
                        cnt   <= tim_in.setup;
                        phase <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        cnt   <= tim_q.strobe - 1'b1;
                        phase <= PH_STRB;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_STRB: begin
                    if (cnt == '0) phase <= PH_RECOV;
                    else           cnt   <= cnt - 1'b1;
                end
                PH_RECOV: begin
                    if (tim_q.hold == '0) begin
                        phase <= PH_IDLE;
                    end else begin
                        cnt   <= tim_q.hold - 1'b1;
                        phase <= PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) phase <= PH_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Marks the final strobe-active clock.
    always_comb last_strb = (phase == PH_STRB) && (cnt == '0);

    // Strobe counter never exceeds the latched strobe length (R4).
    p_strb_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STRB) |-> (cnt < tim_q.strobe));

    // The strobe phase is entered only from a finished setup phase (R4).
    p_strb_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_STRB) && ($past(phase) != PH_STRB)) |->
        (($past(phase) == PH_SETUP) && ($past(cnt) == '0)));
endmodule

// File: rtl/lcdb_pinmap.sv
// Pin encoder: maps the sequencer phase onto chip select and the two strobe
// pins for 8080 or 6800 signalling. Mode comes from the latched value
// during an access and from the live input while idle.
module lcdb_pinmap
    import lcdb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t phase,
    input  logic   rd_q,
    input  logic   mode_q,
    input  logic   mode_live,
    output logic   cs_n,
    output logic   oe_n,
    output logic   we_n
);
    logic busy;
    logic strb;
    logic m68;

    // Decode pins from phase and mode.
    always_comb begin
        busy = (phase != PH_IDLE);
        strb = (phase == PH_STRB);
        m68  = busy ? mode_q : mode_live;
        cs_n = !busy;
        if (m68) begin
            oe_n = strb;
            we_n = busy ? rd_q : 1'b1;
        end else begin
            oe_n = !(strb && rd_q);
            we_n = !(strb && !rd_q);
        end
    end

    // 8080 read and write strobes are never active together (R5).
    p_no_dual_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!m68) |-> (oe_n || we_n));

    // 6800 R/W level holds while chip select stays low (R7).
    p_rw_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m68 && !cs_n && $past(!cs_n)) |-> $stable(we_n));
endmodule

// File: rtl/lcd_pbus_master.sv
// LCD parallel bus master top. Accepts one host request at a time, latches
// its fields and the selected timing, runs one asynchronous bus cycle and
// returns read data with a one-clock pulse. Assumes the host holds
// req_valid and the request fields steady until acceptance.
module lcd_pbus_master
    import lcdb_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_mode_6800,
    input  logic          cfg_split_timing,
    input  logic [TW-1:0] cfg_wr_setup,
    input  logic [TW-1:0] cfg_wr_strobe,
    input  logic [TW-1:0] cfg_wr_hold,
    input  logic [TW-1:0] cfg_rd_setup,
    input  logic [TW-1:0] cfg_rd_strobe,
    input  logic [TW-1:0] cfg_rd_hold,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_read,
    input  logic          req_ram,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          lcd_cs_n,
    output logic          lcd_rs,
    output logic          lcd_oe_n,
    output logic          lcd_we_n,
    output logic [DW-1:0] lcd_d_out,
    output logic          lcd_d_oe,
    input  logic [DW-1:0] lcd_d_in
);
    timing_t       tim_sel;
    phase_t        phase;
    logic          last_strb;
    logic          accept;
    logic          rd_q;
    logic          rs_q;
    logic          mode_q;
    logic [DW-1:0] wdata_q;

    // Handshake: ready only when the sequencer is idle.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        accept    = req_valid && req_ready;
    end

    lcdb_tsel u_tsel (
        .split     (cfg_split_timing),
        .is_read   (req_read),
        .wr_setup  (cfg_wr_setup),
        .wr_strobe (cfg_wr_strobe),
        .wr_hold   (cfg_wr_hold),
        .rd_setup  (cfg_rd_setup),
        .rd_strobe (cfg_rd_strobe),
        .rd_hold   (cfg_rd_hold),
        .tim       (tim_sel)
    );

    lcdb_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .tim_in    (tim_sel),
        .phase     (phase),
        .last_strb (last_strb)
    );

    // Latch the request fields and mode on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            rs_q    <= 1'b0;
            mode_q  <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            rd_q    <= req_read;
            rs_q    <= req_ram;
            mode_q  <= cfg_mode_6800;
            wdata_q <= req_wdata;
        end
    end

    // Capture read data on the edge that ends the last strobe clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= last_strb && rd_q;
            if (last_strb && rd_q) rsp_rdata <= lcd_d_in;
        end
    end

    lcdb_pinmap u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .rd_q      (rd_q),
        .mode_q    (mode_q),
        .mode_live (cfg_mode_6800),
        .cs_n      (lcd_cs_n),
        .oe_n      (lcd_oe_n),
        .we_n      (lcd_we_n)
    );

    // Data bus and register select follow the latched request.
    always_comb begin
        lcd_rs    = rs_q;
        lcd_d_oe  = (phase != PH_IDLE) && !rd_q;
        lcd_d_out = wdata_q;
    end

    p_idle_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> lcd_cs_n);

    p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !lcd_cs_n));

    p_rs_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_rs));

    p_rsp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_wdata_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_d_oe && $past(lcd_d_oe)) |-> $stable(lcd_d_out));
endmodule

// File: tb/lcd_pbus_master_bench.sv
// Scoreboard bench: the driver pushes the expected shape of each access,
// a negedge monitor measures the pins and compares at chip-select release.
module lcd_pbus_master_bench;
    import lcdb_pkg::*;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_mode_6800 = 1'b0;
    logic          cfg_split_timing = 1'b0;
    logic [TW-1:0] cfg_wr_setup = '0, cfg_wr_strobe = '0, cfg_wr_hold = '0;
    logic [TW-1:0] cfg_rd_setup = '0, cfg_rd_strobe = '0, cfg_rd_hold = '0;
    logic          req_valid = 1'b0, req_read = 1'b0, req_ram = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          lcd_cs_n, lcd_rs, lcd_oe_n, lcd_we_n, lcd_d_oe;
    logic [DW-1:0] lcd_d_out, lcd_d_in;
    logic [DW-1:0] rd_model = '0;
    logic          model_rd_strb;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        bit            rd;
        bit            rs;
        bit            m68;
        logic [DW-1:0] dat;
        int            cs_len;
        int            st_len;
        int            st_first;
    } exp_t;

    exp_t sbq[$];

    always #2 clk = ~clk;

    lcd_pbus_master u_lcd_pbus_master (
        .clk(clk), .rst_n(rst_n),
        .cfg_mode_6800(cfg_mode_6800), .cfg_split_timing(cfg_split_timing),
        .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
        .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
        .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
        .req_ram(req_ram), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_oe_n(lcd_oe_n), .lcd_we_n(lcd_we_n),
        .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in)
    );

    // LCD model: valid read data only while the read strobe is active.
    always_comb begin
        if (cfg_mode_6800) model_rd_strb = !lcd_cs_n && lcd_oe_n && lcd_we_n;
        else               model_rd_strb = !lcd_cs_n && !lcd_oe_n;
        lcd_d_in = model_rd_strb ? rd_model : 16'hBAD0;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor state.
    int cs_cnt = 0, st_cnt = 0, first_at = 0;
    int pin_err = 0, rs_err = 0, dat_err = 0, rdy_err = 0, rsp_cnt = 0, rsp_err = 0;
    int rsp_last = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            cs_cnt = 0; st_cnt = 0;
        end else if (!lcd_cs_n) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R2 access without request", 0, 1);
            end else begin
                exp_t c;
                bit strb;
                c = sbq[0];
                strb = c.m68 ? lcd_oe_n : (c.rd ? !lcd_oe_n : !lcd_we_n);
                if (strb) begin
                    if (st_cnt == 0) first_at = cs_cnt;
                    st_cnt++;
                end
                if (c.m68) begin
                    if (lcd_we_n != c.rd) pin_err++;
                end else begin
                    if (c.rd ? !lcd_we_n : !lcd_oe_n) pin_err++;
                end
                if (lcd_rs != c.rs) rs_err++;
                if (c.rd) begin
                    if (lcd_d_oe) dat_err++;
                end else if (!lcd_d_oe || lcd_d_out != c.dat) dat_err++;
                if (req_ready) rdy_err++;
                if (rsp_valid) begin
                    rsp_cnt++;
                    rsp_last = int'(rsp_rdata);
                    if (rsp_rdata != c.dat) rsp_err++;
                end
            end
            cs_cnt++;
        end else if (cs_cnt != 0) begin
            exp_t c;
            c = sbq.pop_front();
            chk(cs_cnt == c.cs_len, "R3 cs low length", cs_cnt, c.cs_len);
            chk(st_cnt == c.st_len, "R4 strobe length", st_cnt, c.st_len);
            chk(first_at == c.st_first, "R4 strobe start", first_at, c.st_first);
            chk(rdy_err == 0, "R2 ready low while busy", rdy_err, 0);
            chk(rs_err == 0, "R5 register select", rs_err, 0);
            chk(dat_err == 0, "R8 data bus drive", dat_err, 0);
            if (c.m68) chk(pin_err == 0, "R7 6800 R/W level", pin_err, 0);
            else if (c.rd) chk(pin_err == 0, "R6 8080 read pins", pin_err, 0);
            else chk(pin_err == 0, "R5 8080 write pins", pin_err, 0);
            chk(rsp_cnt == (c.rd ? 1 : 0), "R6 response pulse count", rsp_cnt, c.rd ? 1 : 0);
            if (c.rd) chk(rsp_err == 0, "R6 read data", rsp_last, int'(c.dat));
            cs_cnt = 0; st_cnt = 0; first_at = 0;
            pin_err = 0; rs_err = 0; dat_err = 0; rdy_err = 0; rsp_cnt = 0; rsp_err = 0;
        end else if (rsp_valid) begin
            chk(1'b0, "R6 response outside access", 1, 0);
        end
    end

    // Driver: one access, with optional mid-access config change (R10).
    task automatic access(input bit rd, input bit rsv, input logic [DW-1:0] dat,
                          input bit m68, input bit split,
                          input int ws, input int wd, input int wh,
                          input int rs_, input int rd_, input int rh,
                          input bit perturb);
        exp_t e;
        int s, d, h;
        bit use_rd;
        use_rd = split && rd;
        s = use_rd ? rs_ : ws;
        d = use_rd ? rd_ : wd;
        h = use_rd ? rh : wh;
        if (d == 0) d = 1;
        @(negedge clk);
        cfg_mode_6800 = m68; cfg_split_timing = split;
        cfg_wr_setup = TW'(ws); cfg_wr_strobe = TW'(wd); cfg_wr_hold = TW'(wh);
        cfg_rd_setup = TW'(rs_); cfg_rd_strobe = TW'(rd_); cfg_rd_hold = TW'(rh);
        req_read = rd; req_ram = rsv; req_wdata = rd ? 16'h0 : dat;
        rd_model = dat;
        e.rd = rd; e.rs = rsv; e.m68 = m68; e.dat = dat;
        e.cs_len = (s + 1) + (d + 1) + h;
        e.st_len = d;
        e.st_first = s + 1;
        sbq.push_back(e);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = ~dat;
        req_ram = ~rsv;
        if (perturb) begin
            cfg_wr_setup = 8'd7; cfg_wr_strobe = 8'd9; cfg_wr_hold = 8'd6;
            cfg_rd_setup = 8'd7; cfg_rd_strobe = 8'd9; cfg_rd_hold = 8'd6;
            cfg_split_timing = ~split;
        end
        do @(negedge clk); while (!req_ready);
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state, 8080 idle pins.
        chk(lcd_cs_n && lcd_oe_n && lcd_we_n, "R1 idle pins in reset",
            {lcd_cs_n, lcd_oe_n, lcd_we_n}, 3'b111);
        chk(!rsp_valid && !lcd_d_oe, "R1 outputs quiet in reset", {rsp_valid, lcd_d_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && lcd_cs_n, "R1 ready after reset", {req_ready, lcd_cs_n}, 2'b11);

        // R5/R3: default timing register write, then RAM write.
        access(0, 0, 16'h0022, 0, 0, 1, 5, 0, 0, 0, 0, 0);
        access(0, 1, 16'hF81F, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // R3: nonzero hold.
        access(0, 1, 16'h07E0, 0, 0, 2, 3, 3, 0, 0, 0, 0);
        // R3: strobe of zero clamps to one.
        access(0, 0, 16'h1234, 0, 0, 0, 0, 2, 0, 0, 0, 0);
        // R6/R9: read with shared set uses the write set.
        access(1, 1, 16'hA5C3, 0, 0, 1, 2, 1, 4, 6, 2, 0);
        // R6/R9: read with split uses the read set.
        access(1, 0, 16'h5A3C, 0, 1, 1, 2, 1, 4, 6, 2, 0);
        // R9: write with split still uses the write set.
        access(0, 1, 16'h0F0F, 0, 1, 1, 2, 1, 4, 6, 2, 0);
        // R7: 6800 write and read.
        access(0, 1, 16'hC0DE, 1, 0, 1, 3, 1, 0, 0, 0, 0);
        access(1, 0, 16'h3E3E, 1, 1, 0, 0, 0, 2, 4, 1, 0);
        chk(!lcd_oe_n && lcd_we_n && lcd_cs_n, "R7 6800 idle pins",
            {lcd_oe_n, lcd_we_n}, 2'b01);
        chk(req_ready && !lcd_d_oe, "R1 idle after 6800 access", {req_ready, lcd_d_oe}, 2'b10);
        // R10: config changed mid-access has no effect, in both modes.
        access(0, 1, 16'h8001, 0, 0, 1, 2, 0, 0, 0, 0, 1);
        access(1, 1, 16'h4002, 0, 1, 0, 1, 0, 2, 3, 1, 1);
        access(1, 0, 16'h2004, 1, 0, 2, 2, 2, 0, 0, 0, 1);
        // Patterned sweep over setup, strobe and hold.
        for (int i = 0; i < 6; i++) begin
            access(i[0], i[1], 16'(16'h1111 * (i + 1)), 1'(i > 3), 1'(i[2]),
                   i % 3, i % 4, i % 2, (i + 1) % 3, i % 5, (i + 1) % 2, 0);
        end
        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R2 every request completed", sbq.size(), 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule